// File: doc/BRIEF.md
# SMBus Serial Data Shift Register

This block is the byte-wide data register of a two-wire serial byte engine. One side faces a CPU register port, where software loads a byte to send or collects a byte that has arrived. The other side faces the bit-level bus sequencer. For each bit, the sequencer gives a shift strobe and the value it sampled on the data line. The register presents the next bit to drive.

The block samples the line on every bit, including the bits it is driving. After eight strobes it therefore holds the byte that was really on the wire. If another master pulls the line low while this one drives a one, the register still ends with the true bus byte, so the engine can carry on as a slave receiver. The block reports that collision as a one-cycle arbitration pulse.

A byte-complete flag (SI), owned by the surrounding control logic, decides when the CPU may touch the register. While the flag is set, the register is frozen for the CPU. While the interface is enabled and the flag is clear, a byte may be in flight, so CPU writes are refused and can be flagged.

Top module: `smb_data_shifter`

## Requirements
- R1: The outgoing bit `sda_out` always equals bit 7 of the register, so successive strobes put a loaded byte on the line starting with its most significant bit.
- R2: After eight strobes with `tx_mode` low, the bit sampled at the first strobe is read back in bit 7, and the bit sampled at the last strobe is read back in bit 0.
- R3: Each accepted strobe moves bits 6..0 up to bits 7..1 and places the sampled `sda_in` in bit 0, in the same cycle. After a byte, the register equals the line values of that byte, which is the bitwise AND of the driven byte and any other driver.
- R4: When `tx_mode` is 1, a strobe that drives 1 and samples 0 gives one `arb_lost` pulse in the next cycle. Shifting goes on unchanged, and the final content is the bus byte.
- R5: While `si_flag` is 1, shift strobes have no effect. The register changes only through an accepted CPU write.
- R6: `byte_done` pulses for exactly one cycle after the eighth accepted strobe of a byte, and the bit count then restarts from zero.
- R7: A CPU write to address 0xC2 loads the register when `si_flag` is 1 or `enable` is 0. A write to any other address changes nothing.
- R8: With `enable` 1 and `si_flag` 0, a CPU access to 0xC2 does not change the register or disturb the byte in flight. It raises `acc_err` for one cycle when the error-report option is on (default).
- R9: After reset the register reads 0x00, `sda_out` is 0, and `byte_done`, `arb_lost` and `acc_err` are 0.
- R10: `cpu_rdata` shows the register while `cpu_rd` is 1 at address 0xC2, and shows zero otherwise.
- R11: While `enable` is 0, shift strobes are ignored and the bit count is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enabled |
| si_flag | input | 1 | Byte-complete flag from control logic |
| tx_mode | input | 1 | This node is driving the line (transmitter) |
| shift_stb | input | 1 | One-cycle per-bit shift strobe from the sequencer |
| sda_in | input | 1 | Data line value sampled by the sequencer |
| sda_out | output | 1 | Bit to drive on the data line |
| byte_done | output | 1 | Pulse after the eighth bit of a byte |
| arb_lost | output | 1 | Pulse when a driven one was read back as zero |
| cpu_addr | input | 8 | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| acc_err | output | 1 | Pulse on a refused access while a byte is in flight |

## Verification
The assertions assume that the sequencer strobes only while `si_flag` is low and raises `si_flag` after `byte_done`, so a byte is always exactly eight accepted strobes. They also assume that `sda_in` is the wired-AND of `sda_out` and the other drivers whenever `tx_mode` is set. The bench works as that sequencer. It derives each sampled bit from the model's current top bit ANDed with a chosen foreign pattern, clears the flag only between whole bytes, and issues refused CPU accesses mid-byte on cycles without a strobe, so the model's byte count stays aligned with the design's.

// File: rtl/smb_data_pkg.sv
package smb_data_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE   = 2'd0,
      ACC_LOAD   = 2'd1,
      ACC_REJECT = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/smb_bit_counter.sv
module smb_bit_counter #(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic shift_en,
   output logic byte_done
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!enable) begin
            cnt_q <= '0;
         end else if (shift_en) begin
            if (cnt_q == LAST) begin
               cnt_q     <= '0;
               byte_done <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done); // R6
   AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(shift_en)); // R6
   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !byte_done); // R11
endmodule

// File: rtl/smb_shift_core.sv
module smb_shift_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              sda_in,
   input  logic              tx_mode,
   input  logic              si_flag,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] reg_q,
   output logic              sda_out,
   output logic              arb_lost
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q    <= '0;
         arb_lost <= 1'b0;
      end else begin
         arb_lost <= 1'b0;
         if (load_en) begin
            reg_q <= load_data;
         end else if (shift_en) begin
            reg_q    <= {reg_q[DATA_W-2:0], sda_in};
            arb_lost <= tx_mode & reg_q[DATA_W-1] & ~sda_in;
         end
      end
   end

   assign sda_out = reg_q[DATA_W-1];

   AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en) |=> reg_q[DATA_W-1:1] == $past(reg_q[DATA_W-2:0])); // R1
   AST_SHIFT_SAMPLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en) |=> reg_q[0] == $past(sda_in)); // R3
   AST_SI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (si_flag && !load_en) |=> reg_q == $past(reg_q)); // R5
   AST_ARB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> ($past(tx_mode) && !$past(sda_in))); // R4
endmodule

// File: rtl/smb_cpu_port.sv
module smb_cpu_port
   import smb_data_pkg::*;
#(
   parameter int               DATA_W     = 8,
   parameter int               ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'hC2,
   parameter bit               REPORT_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              si_flag,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [DATA_W-1:0] reg_q,
   output logic              load_en,
   output logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              acc_err
);
   logic      hit;
   logic      busy;
   acc_kind_e kind;

   assign hit  = (cpu_addr == REG_ADDR);
   assign busy = enable & ~si_flag;

   always_comb begin
      kind = ACC_IDLE;
      if (hit && (cpu_wr || cpu_rd)) begin
         if (busy)        kind = ACC_REJECT;
         else if (cpu_wr) kind = ACC_LOAD;
      end
   end

   assign load_en   = (kind == ACC_LOAD);
   assign load_data = cpu_wdata;
   assign cpu_rdata = (cpu_rd && hit) ? reg_q : '0;

   generate
      if (REPORT_ERR) begin : g_err_flag
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= (kind == ACC_REJECT);
         end
         assign acc_err = err_q;
         AST_ERR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            acc_err |-> ($past(enable) && !$past(si_flag))); // R8
      end else begin : g_err_silent
         assign acc_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/smb_data_shifter.sv
module smb_data_shifter #(
   parameter int               DATA_W     = 8,
   parameter int               ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'hC2,
   parameter bit               REPORT_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              si_flag,
   input  logic              tx_mode,
   input  logic              shift_stb,
   input  logic              sda_in,
   output logic              sda_out,
   output logic              byte_done,
   output logic              arb_lost,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              acc_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("smb_data_shifter: DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("smb_data_shifter: ADDR_W must be at least 1");
      end
   endgenerate

   logic              shift_en;
   logic              load_en;
   logic [DATA_W-1:0] load_data;
   logic [DATA_W-1:0] reg_q;

   assign shift_en = enable & shift_stb & ~si_flag;

   smb_cpu_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .REPORT_ERR(REPORT_ERR)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .enable(enable), .si_flag(si_flag),
      .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
      .reg_q(reg_q), .load_en(load_en), .load_data(load_data),
      .cpu_rdata(cpu_rdata), .acc_err(acc_err)
   );

   smb_shift_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sda_in(sda_in),
      .tx_mode(tx_mode), .si_flag(si_flag), .load_en(load_en), .load_data(load_data),
      .reg_q(reg_q), .sda_out(sda_out), .arb_lost(arb_lost)
   );

   smb_bit_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .enable(enable), .shift_en(shift_en),
      .byte_done(byte_done)
   );

   AST_BUSY_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !si_flag && cpu_wr && cpu_addr == REG_ADDR && !shift_stb)
      |=> reg_q == $past(reg_q)); // R8
   AST_DISABLED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !(cpu_wr && cpu_addr == REG_ADDR)) |=> reg_q == $past(reg_q)); // R11
   AST_OTHER_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (si_flag && cpu_addr != REG_ADDR) |=> reg_q == $past(reg_q)); // R7
endmodule

// File: tb/smb_data_shifter_test.sv
module smb_data_shifter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0, si_flag = 1'b1, tx_mode = 1'b0;
   logic       shift_stb = 1'b0, sda_in = 1'b1;
   logic       sda_out, byte_done, arb_lost, acc_err;
   logic [7:0] cpu_addr = 8'h00, cpu_wdata = 8'h00, cpu_rdata;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;

   int n_run = 0, n_fail = 0;
   logic [7:0] model;

   always #10 clk = ~clk;

   smb_data_shifter uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .si_flag(si_flag), .tx_mode(tx_mode),
      .shift_stb(shift_stb), .sda_in(sda_in), .sda_out(sda_out), .byte_done(byte_done),
      .arb_lost(arb_lost), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .acc_err(acc_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic read_check(input logic [7:0] exp, input string req);
      cpu_addr = 8'hC2; cpu_rd = 1'b1;
      #1 check(cpu_rdata == exp, req, cpu_rdata, exp);
      cpu_rd = 1'b0;
   endtask

   // one bit: check driven bit, strobe, then check pulses
   task automatic one_bit(input int i, input logic other, input logic txm);
      logic drv, bus, exp_arb;
      drv = model[7];
      check(sda_out == drv, "R1 sda_out", sda_out, drv);
      bus = txm ? (drv & other) : other;
      exp_arb = txm & drv & ~bus;
      shift_stb = 1'b1; sda_in = bus;
      @(negedge clk);
      shift_stb = 1'b0; sda_in = 1'b1;
      model = {model[6:0], bus};
      check(arb_lost == exp_arb, "R4 arb_lost", arb_lost, exp_arb);
      check(byte_done == (i == 0), "R6 byte_done", byte_done, (i == 0));
   endtask

   task automatic do_byte(input logic [7:0] tx, input logic [7:0] other, input logic txm,
                          input string req);
      si_flag = 1'b1; tx_mode = txm;
      cpu_write(8'hC2, tx);
      model = tx;
      si_flag = 1'b0;
      for (int i = 7; i >= 0; i--) one_bit(i, other[i], txm);
      si_flag = 1'b1;
      read_check(txm ? (tx & other) : other, req);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R9 reset state
      check(sda_out == 1'b0, "R9 sda_out", sda_out, 0);
      check(!byte_done && !arb_lost && !acc_err, "R9 pulses",
            {byte_done, arb_lost, acc_err}, 0);
      read_check(8'h00, "R9 reset value");
      rst_n = 1'b1; enable = 1'b1;
      @(negedge clk);

      // R1 R3 transmit sweep with a free bus
      for (int b = 0; b < 256; b++) do_byte(8'(b), 8'hFF, 1'b1, "R3 tx byte");
      // R2 receive sweep
      for (int b = 0; b < 256; b++) do_byte(8'hFF, 8'(b), 1'b0, "R2 rx byte");
      // R4 lost arbitration at each bit position
      for (int k = 0; k < 8; k++)
         for (int b = 0; b < 256; b += 9)
            do_byte(8'(b) | 8'(1 << k), ~8'(1 << k), 1'b1, "R4 bus byte");

      // R5 strobes while SI set are ignored
      si_flag = 1'b1; cpu_write(8'hC2, 8'hA5);
      shift_stb = 1'b1; sda_in = 1'b0;
      repeat (3) @(negedge clk);
      shift_stb = 1'b0; sda_in = 1'b1;
      read_check(8'hA5, "R5 frozen while SI");
      check(!byte_done, "R5 no done", byte_done, 0);

      // R7 wrong address write ignored, R10 wrong address read is zero
      cpu_write(8'hC3, 8'h3C);
      read_check(8'hA5, "R7 other address write");
      cpu_addr = 8'hC1; cpu_rd = 1'b1;
      #1 check(cpu_rdata == 8'h00, "R10 other address read", cpu_rdata, 0);
      cpu_rd = 1'b0;
      cpu_addr = 8'hC2;
      #1 check(cpu_rdata == 8'h00, "R10 no read strobe", cpu_rdata, 0);

      // R8 busy write mid-byte: refused, flagged, shift unharmed
      si_flag = 1'b1; tx_mode = 1'b1; cpu_write(8'hC2, 8'h96); model = 8'h96;
      si_flag = 1'b0;
      for (int i = 7; i >= 5; i--) one_bit(i, 1'b1, 1'b1);
      cpu_write(8'hC2, 8'h00);
      check(acc_err == 1'b1, "R8 acc_err", acc_err, 1);
      check(sda_out == model[7], "R8 sda_out unchanged", sda_out, model[7]);
      @(negedge clk);
      check(acc_err == 1'b0, "R8 acc_err one cycle", acc_err, 0);
      for (int i = 4; i >= 0; i--) one_bit(i, 1'b1, 1'b1);
      si_flag = 1'b1;
      read_check(8'h96, "R8 byte intact");

      // R11 disabled: strobes ignored, write allowed, count restarts
      enable = 1'b0; si_flag = 1'b0;
      cpu_write(8'hC2, 8'h5A);
      shift_stb = 1'b1; sda_in = 1'b0;
      repeat (4) @(negedge clk);
      shift_stb = 1'b0; sda_in = 1'b1;
      check(!byte_done, "R11 no done", byte_done, 0);
      read_check(8'h5A, "R7 write while disabled / R11 no shift");
      enable = 1'b1;
      si_flag = 1'b1;
      @(negedge clk);
      do_byte(8'hC3, 8'hFF, 1'b1, "R11 count restart");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule